// File: doc/BRIEF.md
# Codec Power-State and Initialization Sequencer

This block decides the power state of a register-controlled audio converter. It takes two active-low hardware pins, a sleep pin and a hard-reset pin, along with a sample-period strobe and a small write/read register bus. From these it works out one operating mode. It then drives the enables for the ADC, DAC, mixer and voltage reference, a FIFO flush request, a DAC mute, and a bus output enable that the pad ring uses to tri-state the data lines.

The hardware pins always win over software. A low sleep pin drops everything at once. A low hard-reset pin mutes the DAC first and shuts the rest down after a counted drain period. When both pins are high, a long counted initialization runs. During it, reads return a fixed busy byte and writes are discarded. When it ends, the registers hold their defaults with the configuration-unlock bit set.

Software can request a full-off state, but only while unlocked. Clearing that request re-runs initialization. The per-converter power-down bits take effect on the next sample strobe. A clock-selection change, made while unlocked with the extended bit set, runs a resynchronization window that behaves like initialization on the bus.

Top module: `cpwr_seq_top`

## Requirements
- R1: After synchronous reset the mode is sleep (code 1) with every enable low and `bus_oe` low. Initialization (mode 5) starts only in the cycle after both `sleep_n` and `hard_rst_n` are sampled high. With `sleep_n` high and `hard_rst_n` low, the block sits in halt (mode 3).
- R2: The block stays in initialization for exactly `INIT_CYC` cycles. During that time `busy` is 1, every read returns 0x80, writes are discarded, and all converter enables are low.
- R3: On leaving initialization the mode is run (code 0), and ADC, DAC, mixer and reference are enabled. The register map is fixed:
  - address 0: bit0 = unlock, bit1 = extended; default 0x01.
  - address 1: bit0 = ADC off, bit1 = DAC off, bit2 = mixer off; default 0x00.
  - address 2: bit0 = full-off; default 0x00.
  - address 3: bits 2:0 = clock select; default 0x00.
  - Unused bits read 0.
- R4: A low `sleep_n` puts the block in sleep (code 1) on the next clock from any mode, including the drain sequence. All enables are then low and `bus_oe` is low.
- R5: A low `hard_rst_n` with `sleep_n` high enters drain (code 2) for exactly `RST_CYC` cycles. During drain `dac_mute` is 1, `dac_en` is 0, ADC, mixer and reference stay enabled, and `bus_oe` is 0. The block then goes to halt (code 3) with all enables and the mute low.
- R6: A write of 1 to the full-off bit is accepted only while unlock is 1. One cycle after it is stored, the mode becomes full-off (code 4). In full-off, converters and reference are disabled, `fifo_flush` is 1, and the bus stays active with real read data.
- R7: Writing 0 to the full-off bit enters initialization on the next clock. This is the same initialization as R2, and it ends with the defaults of R3.
- R8: A per-converter off bit, or its release, reaches the enable output only on the clock that samples `fs_tick` high. The unlock bit is not needed for this.
- R9: A write of a different clock select while in run with unlock and extended both 1 enters resync (code 6) on that clock, for exactly `RESYNC_CYC` cycles. During resync `busy` is 1, reads return 0x80, writes are discarded, converters are off and the reference stays on. The block then returns to run with the new select. The same write with extended 0 is ignored.
- R10: Priority is sleep pin, then hard-reset pin, then full-off. A low hard-reset pin takes the block out of full-off into drain, and a low sleep pin during a hard reset gives sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_n | input | 1 | Hardware sleep pin, active low |
| hard_rst_n | input | 1 | Hardware reset pin, active low |
| fs_tick | input | 1 | One-cycle strobe per sample period |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (0x80 while busy) |
| bus_oe | output | 1 | Bus drive enable; 0 means tri-state |
| adc_en | output | 1 | ADC enable |
| dac_en | output | 1 | DAC enable |
| mix_en | output | 1 | Mixer enable |
| vref_en | output | 1 | Voltage reference enable |
| fifo_flush | output | 1 | Flush both FIFOs |
| dac_mute | output | 1 | Mute DAC output during drain |
| busy | output | 1 | Initialization or resync running |
| mode_o | output | 4 | Resolved mode code |

## Verification
The bench samples the last cycle of each counted window and the cycle after it. A counter loaded off by one would show run a cycle early or late. The bench also writes during initialization and during resync, then reads back after the window ends; a design that still accepts writes there returns the written value instead of the default. The full-off bit is tried both locked and unlocked, and the clock select with and without the extended bit; a missing gate shows up as a stray mode change. Pin priority is checked from full-off and from mid-drain. An inverted priority would leave the block in full-off or drain instead of moving to drain or sleep.

// File: rtl/cpwr_pkg.sv
package cpwr_pkg;

    localparam int UNITS  = 3;
    localparam int U_ADC  = 0;
    localparam int U_DAC  = 1;
    localparam int U_MIX  = 2;
    localparam int ADDR_W = 2;
    localparam int DATA_W = 8;
    localparam int SEL_W  = 3;

    localparam logic [ADDR_W-1:0] A_CTRL  = 2'd0;
    localparam logic [ADDR_W-1:0] A_UNIT  = 2'd1;
    localparam logic [ADDR_W-1:0] A_FULL  = 2'd2;
    localparam logic [ADDR_W-1:0] A_CLK   = 2'd3;

    localparam logic [DATA_W-1:0] BUSY_BYTE = 8'h80;

    typedef enum logic [3:0] {
        M_RUN    = 4'd0,
        M_SLEEP  = 4'd1,
        M_DRAIN  = 4'd2,
        M_HALT   = 4'd3,
        M_ALLOFF = 4'd4,
        M_INIT   = 4'd5,
        M_RESYNC = 4'd6
    } mode_e;

    typedef struct packed {
        logic             unlock;
        logic             ext;
        logic [UNITS-1:0] unit_off;
        logic             full_off;
        logic [SEL_W-1:0] clk_sel;
    } cfg_s;

    localparam cfg_s CFG_DEFAULT = '{
        unlock:   1'b1,
        ext:      1'b0,
        unit_off: '0,
        full_off: 1'b0,
        clk_sel:  '0
    };

    function automatic int imax3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Pins have removed the block from service.
    function automatic logic pin_off(input mode_e m);
        return (m == M_SLEEP) || (m == M_DRAIN) || (m == M_HALT);
    endfunction

    // Bus reads report the busy byte.
    function automatic logic is_busy(input mode_e m);
        return (m == M_INIT) || (m == M_RESYNC);
    endfunction

    // Registers are held at their defaults.
    function automatic logic cfg_hold(input mode_e m);
        return pin_off(m) || (m == M_INIT);
    endfunction

    function automatic logic accepts_write(input mode_e m);
        return (m == M_RUN) || (m == M_ALLOFF);
    endfunction

    // Drain keeps ADC and mixer alive, DAC goes quiet first.
    function automatic logic unit_allowed(input mode_e m, input int idx);
        if (m == M_RUN)
            return 1'b1;
        if (m == M_DRAIN)
            return idx != U_DAC;
        return 1'b0;
    endfunction

endpackage

// File: rtl/cpwr_mode_fsm.sv
module cpwr_mode_fsm
    import cpwr_pkg::*;
#(
    parameter int INIT_CYC   = 1024,
    parameter int RST_CYC    = 16,
    parameter int RESYNC_CYC = 1024
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  sleep_n,
    input  logic  hard_rst_n,
    input  logic  full_off,
    input  logic  resync_req,
    output mode_e mode
);

    localparam int MAX_CYC = imax3(INIT_CYC, RST_CYC, RESYNC_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    localparam logic [CNT_W-1:0] LD_INIT   = CNT_W'(INIT_CYC - 1);
    localparam logic [CNT_W-1:0] LD_DRAIN  = CNT_W'(RST_CYC - 1);
    localparam logic [CNT_W-1:0] LD_RESYNC = CNT_W'(RESYNC_CYC - 1);

    mode_e            mode_q, mode_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             cnt_done;

    assign cnt_done = (cnt_q == '0);

    always_comb begin
        mode_d = mode_q;
        cnt_d  = cnt_done ? cnt_q : cnt_q - 1'b1;
        if (!sleep_n) begin
            mode_d = M_SLEEP;
            cnt_d  = '0;
        end else if (!hard_rst_n) begin
            unique case (mode_q)
                M_DRAIN: begin
                    if (cnt_done) mode_d = M_HALT;
                end
                M_HALT, M_SLEEP: begin
                    mode_d = M_HALT;
                    cnt_d  = '0;
                end
                default: begin
                    mode_d = M_DRAIN;
                    cnt_d  = LD_DRAIN;
                end
            endcase
        end else begin
            unique case (mode_q)
                M_SLEEP, M_DRAIN, M_HALT: begin
                    mode_d = M_INIT;
                    cnt_d  = LD_INIT;
                end
                M_INIT, M_RESYNC: begin
                    if (cnt_done) mode_d = M_RUN;
                end
                M_RUN: begin
                    if (resync_req) begin
                        mode_d = M_RESYNC;
                        cnt_d  = LD_RESYNC;
                    end else if (full_off) begin
                        mode_d = M_ALLOFF;
                    end
                end
                M_ALLOFF: begin
                    if (!full_off) begin
                        mode_d = M_INIT;
                        cnt_d  = LD_INIT;
                    end
                end
                default: begin
                    mode_d = M_SLEEP;
                    cnt_d  = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= M_SLEEP;
            cnt_q  <= '0;
        end else begin
            mode_q <= mode_d;
            cnt_q  <= cnt_d;
        end
    end

    assign mode = mode_q;

endmodule

// File: rtl/cpwr_regfile.sv
module cpwr_regfile
    import cpwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  mode_e             mode,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output cfg_s              cfg,
    output logic              resync_req,
    output logic [DATA_W-1:0] rdata
);

    cfg_s cfg_q;
    logic wr_ok;
    logic hit_ctrl, hit_unit, hit_full, hit_clk;
    logic unused_hi;

    assign unused_hi = ^wdata[DATA_W-1:SEL_W];

    always_comb begin
        wr_ok      = wr_en && accepts_write(mode);
        hit_ctrl   = wr_ok && (addr == A_CTRL);
        hit_unit   = wr_ok && (addr == A_UNIT);
        hit_full   = wr_ok && (addr == A_FULL) && cfg_q.unlock;
        hit_clk    = wr_ok && (addr == A_CLK) && (mode == M_RUN)
                     && cfg_q.unlock && cfg_q.ext;
        resync_req = hit_clk && (wdata[SEL_W-1:0] != cfg_q.clk_sel);
    end

    always_ff @(posedge clk) begin
        if (rst || cfg_hold(mode)) begin
            cfg_q <= CFG_DEFAULT;
        end else begin
            if (hit_ctrl) begin
                cfg_q.unlock <= wdata[0];
                cfg_q.ext    <= wdata[1];
            end
            if (hit_unit) cfg_q.unit_off <= wdata[UNITS-1:0];
            if (hit_full) cfg_q.full_off <= wdata[0];
            if (hit_clk)  cfg_q.clk_sel  <= wdata[SEL_W-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (is_busy(mode)) begin
            rdata = BUSY_BYTE;
        end else if (!pin_off(mode)) begin
            unique case (addr)
                A_CTRL:  rdata = {{(DATA_W-2){1'b0}}, cfg_q.ext, cfg_q.unlock};
                A_UNIT:  rdata = {{(DATA_W-UNITS){1'b0}}, cfg_q.unit_off};
                A_FULL:  rdata = {{(DATA_W-1){1'b0}}, cfg_q.full_off};
                default: rdata = {{(DATA_W-SEL_W){1'b0}}, cfg_q.clk_sel};
            endcase
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/cpwr_unit_gate.sv
module cpwr_unit_gate (
    input  logic clk,
    input  logic rst,
    input  logic fs_tick,
    input  logic clear,
    input  logic off_req,
    input  logic allow,
    output logic en
);

    logic off_q;

    always_ff @(posedge clk) begin
        if (rst || clear)
            off_q <= 1'b0;
        else if (fs_tick)
            off_q <= off_req;
    end

    assign en = allow && !off_q;

endmodule

// File: rtl/cpwr_seq_top.sv
module cpwr_seq_top
    import cpwr_pkg::*;
#(
    parameter int CLK_KHZ    = 24576,
    parameter int INIT_CYC   = CLK_KHZ * 512,
    parameter int RST_CYC    = CLK_KHZ * 3,
    parameter int RESYNC_CYC = CLK_KHZ * 512
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sleep_n,
    input  logic       hard_rst_n,
    input  logic       fs_tick,
    input  logic       wr_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       bus_oe,
    output logic       adc_en,
    output logic       dac_en,
    output logic       mix_en,
    output logic       vref_en,
    output logic       fifo_flush,
    output logic       dac_mute,
    output logic       busy,
    output logic [3:0] mode_o
);

    mode_e            mode;
    cfg_s             cfg;
    logic             resync_req;
    logic [UNITS-1:0] unit_en;

    cpwr_mode_fsm #(
        .INIT_CYC   (INIT_CYC),
        .RST_CYC    (RST_CYC),
        .RESYNC_CYC (RESYNC_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .sleep_n    (sleep_n),
        .hard_rst_n (hard_rst_n),
        .full_off   (cfg.full_off),
        .resync_req (resync_req),
        .mode       (mode)
    );

    cpwr_regfile u_regs (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .cfg        (cfg),
        .resync_req (resync_req),
        .rdata      (rdata)
    );

    for (genvar u = 0; u < UNITS; u++) begin : g_unit
        cpwr_unit_gate u_gate (
            .clk     (clk),
            .rst     (rst),
            .fs_tick (fs_tick),
            .clear   (cfg_hold(mode)),
            .off_req (cfg.unit_off[u]),
            .allow   (unit_allowed(mode, u)),
            .en      (unit_en[u])
        );
    end

    assign adc_en     = unit_en[U_ADC];
    assign dac_en     = unit_en[U_DAC];
    assign mix_en     = unit_en[U_MIX];
    assign vref_en    = (mode == M_RUN) || (mode == M_DRAIN) || (mode == M_RESYNC);
    assign fifo_flush = (mode == M_ALLOFF);
    assign dac_mute   = (mode == M_DRAIN);
    assign bus_oe     = !pin_off(mode);
    assign busy       = is_busy(mode);
    assign mode_o     = mode;

endmodule

// File: rtl/cpwr_seq_chk.sv
module cpwr_seq_chk
    import cpwr_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       sleep_n,
    input logic       hard_rst_n,
    input logic       fs_tick,
    input logic [7:0] rdata,
    input logic       bus_oe,
    input logic       adc_en,
    input logic       dac_en,
    input logic       mix_en,
    input logic       vref_en,
    input logic       fifo_flush,
    input logic       dac_mute,
    input logic       busy,
    input logic [3:0] mode_o
);

    // R1
    init_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!sleep_n || !hard_rst_n) |=> (mode_o != M_INIT));

    // R2
    busy_read_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (rdata == 8'h80 && !adc_en && !dac_en && !mix_en));

    // R4
    sleep_off_chk: assert property (@(posedge clk) disable iff (rst)
        !sleep_n |=> (mode_o == M_SLEEP && !bus_oe && !adc_en && !dac_en
                      && !mix_en && !vref_en));

    // R5
    drain_mute_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o == M_DRAIN) |-> (dac_mute && !dac_en && !bus_oe && vref_en));

    // R6
    full_flush_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o == M_ALLOFF) |-> (fifo_flush && bus_oe && !vref_en && !adc_en
                                  && !dac_en && !mix_en));

    // R8
    unit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_o == M_RUN && !fs_tick) |=>
            (mode_o != M_RUN || $stable({adc_en, dac_en, mix_en})));

    // R10
    pin_prio_chk: assert property (@(posedge clk) disable iff (rst)
        (sleep_n && !hard_rst_n) |=> (mode_o == M_DRAIN || mode_o == M_HALT));

endmodule

bind cpwr_seq_top cpwr_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sleep_n    (sleep_n),
    .hard_rst_n (hard_rst_n),
    .fs_tick    (fs_tick),
    .rdata      (rdata),
    .bus_oe     (bus_oe),
    .adc_en     (adc_en),
    .dac_en     (dac_en),
    .mix_en     (mix_en),
    .vref_en    (vref_en),
    .fifo_flush (fifo_flush),
    .dac_mute   (dac_mute),
    .busy       (busy),
    .mode_o     (mode_o)
);

// File: tb/cpwr_seq_top_test.sv
module cpwr_seq_top_test;

    localparam int INIT_N   = 20;
    localparam int DRAIN_N  = 6;
    localparam int RESYNC_N = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sleep_n = 1'b0;
    logic       hard_rst_n = 1'b0;
    logic       fs_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       bus_oe, adc_en, dac_en, mix_en, vref_en;
    logic       fifo_flush, dac_mute, busy;
    logic [3:0] mode_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    cpwr_seq_top #(
        .INIT_CYC   (INIT_N),
        .RST_CYC    (DRAIN_N),
        .RESYNC_CYC (RESYNC_N)
    ) uut (
        .clk(clk), .rst(rst), .sleep_n(sleep_n), .hard_rst_n(hard_rst_n),
        .fs_tick(fs_tick), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .bus_oe(bus_oe), .adc_en(adc_en), .dac_en(dac_en),
        .mix_en(mix_en), .vref_en(vref_en), .fifo_flush(fifo_flush),
        .dac_mute(dac_mute), .busy(busy), .mode_o(mode_o)
    );

    // {addr, write data, expected readback}
    localparam logic [17:0] VECS [0:6] = '{
        {2'd1, 8'h07, 8'h07},
        {2'd1, 8'h00, 8'h00},
        {2'd1, 8'hFD, 8'h05},
        {2'd1, 8'h00, 8'h00},
        {2'd0, 8'h03, 8'h03},
        {2'd0, 8'hFE, 8'h02},
        {2'd0, 8'h01, 8'h01}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rdchk(input string tag, input logic [1:0] a, input logic [7:0] exp);
        addr = a;
        #1;
        chk(tag, {24'd0, rdata}, {24'd0, exp});
    endtask

    task automatic enables(input string tag, input logic [3:0] exp);
        chk(tag, {28'd0, adc_en, dac_en, mix_en, vref_en}, {28'd0, exp});
    endtask

    task automatic tick();
        fs_tick = 1'b1;
        @(negedge clk);
        fs_tick = 1'b0;
    endtask

    task automatic to_run_from_pins();
        sleep_n = 1'b1; hard_rst_n = 1'b1;
        step(INIT_N + 1);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        // R1 reset state
        chk("R1 reset mode", mode_o, 1);
        chk("R1 reset bus_oe", bus_oe, 0);
        enables("R1 reset enables", 4'b0000);

        sleep_n = 1'b1;
        step(2);
        chk("R1 halt while reset pin low", mode_o, 3);

        hard_rst_n = 1'b1;
        step(1);
        chk("R1 init after both pins high", mode_o, 5);
        chk("R2 busy", busy, 1);
        rdchk("R2 busy byte", 2'd0, 8'h80);
        wr(2'd1, 8'h07);
        step(INIT_N - 2);
        chk("R2 last init cycle", mode_o, 5);
        enables("R2 enables off in init", 4'b0000);
        step(1);
        chk("R3 run after init", mode_o, 0);
        enables("R3 enables on", 4'b1111);
        rdchk("R2 write ignored during init", 2'd1, 8'h00);
        rdchk("R3 default ctrl", 2'd0, 8'h01);
        rdchk("R3 default full-off", 2'd2, 8'h00);
        rdchk("R3 default clock select", 2'd3, 8'h00);

        // R3 register map vectors
        for (int i = 0; i < 7; i++) begin
            wr(VECS[i][17:16], VECS[i][15:8]);
            rdchk("R3 readback", VECS[i][17:16], VECS[i][7:0]);
        end

        // R8 unit off waits for strobe
        wr(2'd1, 8'h01);
        chk("R8 adc held before strobe", adc_en, 1);
        tick();
        enables("R8 adc off after strobe", 4'b0111);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h00);
        chk("R8 release waits for strobe", adc_en, 0);
        tick();
        enables("R8 released without unlock", 4'b1111);

        // R6 full-off locked then unlocked
        wr(2'd2, 8'h01);
        rdchk("R6 locked write ignored", 2'd2, 8'h00);
        chk("R6 still run when locked", mode_o, 0);
        wr(2'd0, 8'h01);
        wr(2'd2, 8'h01);
        step(1);
        chk("R6 full-off mode", mode_o, 4);
        chk("R6 flush", fifo_flush, 1);
        chk("R6 bus active", bus_oe, 1);
        enables("R6 all off", 4'b0000);
        rdchk("R6 real read data", 2'd2, 8'h01);

        // R7 clearing full-off reinitializes
        wr(2'd0, 8'h03);
        wr(2'd2, 8'h00);
        step(1);
        chk("R7 init after clear", mode_o, 5);
        rdchk("R7 busy byte", 2'd0, 8'h80);
        step(INIT_N);
        chk("R7 run after init", mode_o, 0);
        rdchk("R7 defaults restored", 2'd0, 8'h01);

        // R9 clock select
        wr(2'd3, 8'h02);
        rdchk("R9 ignored without extended", 2'd3, 8'h00);
        chk("R9 no resync without extended", mode_o, 0);
        wr(2'd0, 8'h03);
        wr(2'd3, 8'h05);
        chk("R9 resync mode", mode_o, 6);
        chk("R9 busy", busy, 1);
        rdchk("R9 busy byte", 2'd1, 8'h80);
        enables("R9 converters off ref on", 4'b0001);
        wr(2'd1, 8'h07);
        step(RESYNC_N - 2);
        chk("R9 last resync cycle", mode_o, 6);
        step(1);
        chk("R9 back to run", mode_o, 0);
        rdchk("R9 new select", 2'd3, 8'h05);
        rdchk("R9 write in resync ignored", 2'd1, 8'h00);

        // R5 drain sequence
        hard_rst_n = 1'b0;
        step(1);
        chk("R5 drain mode", mode_o, 2);
        chk("R5 mute", dac_mute, 1);
        chk("R5 bus off", bus_oe, 0);
        enables("R5 dac off first", 4'b1011);
        step(DRAIN_N - 1);
        chk("R5 last drain cycle", mode_o, 2);
        step(1);
        chk("R5 halt", mode_o, 3);
        chk("R5 mute released", dac_mute, 0);
        enables("R5 all off", 4'b0000);

        // R10 priority
        sleep_n = 1'b0;
        step(1);
        chk("R10 sleep over reset pin", mode_o, 1);
        sleep_n = 1'b1;
        step(1);
        chk("R10 reset pin after sleep release", mode_o, 3);

        // R4 sleep during drain
        to_run_from_pins();
        chk("R4 run before drain", mode_o, 0);
        hard_rst_n = 1'b0;
        step(2);
        chk("R4 mid drain", mode_o, 2);
        sleep_n = 1'b0;
        step(1);
        chk("R4 sleep from drain", mode_o, 1);
        chk("R4 bus off", bus_oe, 0);
        enables("R4 all off", 4'b0000);

        // R10 reset pin overrides full-off
        to_run_from_pins();
        wr(2'd2, 8'h01);
        step(1);
        chk("R10 full-off before pin", mode_o, 4);
        hard_rst_n = 1'b0;
        step(1);
        chk("R10 reset pin over full-off", mode_o, 2);

        done = 1'b1;
        summary();
    end

endmodule